// File: doc/BRIEF.md
# Keyed Index/Data Configuration Register Block

This block is a small configuration register file that the host reaches through two I/O addresses. A write to the index port selects a register offset. Later data-port reads and writes act on the selected register. After reset the block answers at a single offset only, the identification register. Every other register stays silent until the host writes the unlock key `0Fh` into that identification register. Because of this, two devices can share the same index/data port pair without both answering the bus.

Behind the lock there are two registers. One is a read-only revision register. The other is a mode register whose bits 6 and 5 drive two enable outputs: an alternate pin-function group enable and an upper-address page generation enable.

The block has a write channel and a read-request channel, and both are strobed. Each can carry one access per cycle, and both may be active in the same cycle. A read produces a registered response one cycle later. That response is a data-valid flag plus a data byte. A response cannot be stalled, because there is no back-pressure, so the host must take it in the cycle it appears. When the block does not claim a read, it holds the data-valid flag low and the data byte at 00h. This leaves the bus to other devices.

Top module: `cfgport_unlock`

## Requirements
- R1: After reset, the following hold. The index is 00h. The identification register is 00h. The block is locked. The mode register is 20h, so `page_addr_en`=1 and `alt_func_en`=0. `rd_valid` is 0.
- R2: A write to I/O address 22h loads the 8-bit index, which holds until the next such write. A read of address 22h is never claimed (`rd_valid`=0).
- R3: The identification register at offset 02h is always accessible through data port 23h. A write stores the byte, and a data-port read returns it with `rd_valid`=1 on the cycle after the read strobe.
- R4: A write of 0Fh to offset 02h unlocks the block. A write of any other value stores that value and leaves the block locked, or locks it again if it was unlocked.
- R5: While the block is locked, data-port reads of offsets 08h and 40h return `rd_valid`=0, and writes to offset 40h do not change the mode register or the enable outputs.
- R6: Once unlocked, offset 08h reads the revision value (default 02h). Writes to offset 08h have no effect on it.
- R7: Once unlocked, offset 40h stores bits 6:0 of a write. Bit 7 ignores writes and always reads 0.
- R8: `alt_func_en` follows mode bit 6, and `page_addr_en` follows mode bit 5. Both change on the clock edge that takes an accepted write, and not before.
- R9: A data-port read of any offset other than 02h, 08h and 40h is not claimed. Whenever `rd_valid`=0, `rd_data` is 00h.
- R10: Writes to I/O addresses other than 22h and 23h change no state.
- R11: When a read and a write fall in the same cycle, the read answers from the state before that write. This covers the index, the lock state and the register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | I/O write strobe |
| wr_addr | input | 16 | I/O write address |
| wr_data | input | 8 | I/O write data |
| rd_en | input | 1 | I/O read strobe |
| rd_addr | input | 16 | I/O read address |
| rd_valid | output | 1 | Read claimed; `rd_data` is meaningful |
| rd_data | output | 8 | Read response byte (00h when not claimed) |
| alt_func_en | output | 1 | Alternate pin-function group enable (mode bit 6) |
| page_addr_en | output | 1 | Upper-address page generation enable (mode bit 5) |

## Verification
Two functions can fall in the same cycle: a read on the request channel, and a write on the write channel that changes what that read would see. The bench provokes this in two ways. First, it loads a new index while it reads the data port. Second, it writes the unlock key to the identification register while it reads that register. In each case the response is judged against the value held before the edge, such as the old index's register or the old identification byte. Around these cases, sweeps cover all 256 index values in the locked state and in the unlocked state, all 256 identification bytes, and all 256 mode bytes. Each expected value is computed from the register model in the bench.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam int DW = 8;
  typedef logic [DW-1:0] cfg_byte_t;

  localparam cfg_byte_t OFS_ID     = 8'h02;
  localparam cfg_byte_t OFS_REV    = 8'h08;
  localparam cfg_byte_t OFS_MODE   = 8'h40;
  localparam cfg_byte_t UNLOCK_KEY = 8'h0F;
  localparam cfg_byte_t MODE_RST   = 8'h20;
  localparam cfg_byte_t MODE_WMASK = 8'h7F;

  localparam int NUM_EN = 2;
  localparam int EN_ALT = 0;
  localparam int EN_PAGE = 1;
endpackage

// File: rtl/cfgport_decode.sv
module cfgport_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] IDX_PORT = 'h22,
  parameter logic [ADDR_W-1:0] DAT_PORT = 'h23
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              idx_wr,
  output logic              dat_wr,
  output logic              dat_rd
);
  // The index port is write-only; only the data port answers reads.
  assign idx_wr = wr_en && (wr_addr == IDX_PORT);
  assign dat_wr = wr_en && (wr_addr == DAT_PORT);
  assign dat_rd = rd_en && (rd_addr == DAT_PORT);
endmodule

// File: rtl/cfgport_lock.sv
module cfgport_lock
  import cfgport_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      dat_wr,
  input  cfg_byte_t index,
  input  cfg_byte_t wdata,
  output cfg_byte_t id_q,
  output logic      unlocked_q
);
  logic id_sel;
  assign id_sel = dat_wr && (index == OFS_ID);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_q       <= '0;
      unlocked_q <= 1'b0;
    end else if (id_sel) begin
      id_q       <= wdata;
      unlocked_q <= (wdata == UNLOCK_KEY);
    end
  end

  assert_key_unlocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (id_sel && wdata == UNLOCK_KEY) |=> unlocked_q);
  assert_other_relocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (id_sel && wdata != UNLOCK_KEY) |=> !unlocked_q);
  assert_lock_needs_id_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !id_sel |=> $stable(unlocked_q) && $stable(id_q));
endmodule

// File: rtl/cfgport_mode.sv
module cfgport_mode
  import cfgport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dat_wr,
  input  cfg_byte_t         index,
  input  cfg_byte_t         wdata,
  input  logic              unlocked,
  output cfg_byte_t         mode_q,
  output logic [NUM_EN-1:0] en
);
  localparam int EN_BIT [NUM_EN] = '{6, 5};

  logic mode_wr;
  assign mode_wr = dat_wr && unlocked && (index == OFS_MODE);

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= MODE_RST;
    else if (mode_wr) mode_q <= wdata & MODE_WMASK;
  end

  // Each enable is taken straight from a register bit, so it is a registered output.
  for (genvar g = 0; g < NUM_EN; g++) begin : g_en
    assign en[g] = mode_q[EN_BIT[g]];
  end

  assert_mode_frozen_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(mode_q));
  assert_alt_follows_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> en[EN_ALT] == $past(wdata[6]));
  assert_page_follows_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> en[EN_PAGE] == $past(wdata[5]));
  assert_rsvd_bit_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> !mode_q[7]);
endmodule

// File: rtl/cfgport_rdmux.sv
module cfgport_rdmux
  import cfgport_pkg::*;
#(
  parameter cfg_byte_t REV_VALUE = 8'h02
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      dat_rd,
  input  cfg_byte_t index,
  input  logic      unlocked,
  input  cfg_byte_t id_q,
  input  cfg_byte_t mode_q,
  output logic      rd_valid,
  output cfg_byte_t rd_data
);
  logic      hit;
  cfg_byte_t sel;

  always_comb begin
    hit = 1'b0;
    sel = '0;
    case (index)
      OFS_ID:   begin hit = 1'b1;     sel = id_q;                end
      OFS_REV:  begin hit = unlocked; sel = REV_VALUE;           end
      OFS_MODE: begin hit = unlocked; sel = mode_q & MODE_WMASK; end
      default:  begin hit = 1'b0;     sel = '0;                  end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= dat_rd && hit;
      rd_data  <= (dat_rd && hit) ? sel : '0;
    end
  end

  assert_silent_when_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && !unlocked && index != OFS_ID) |=> !rd_valid);
  assert_id_always_claimed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && index == OFS_ID) |=> rd_valid && rd_data == $past(id_q));
  assert_idle_bus_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_data == '0);
  assert_no_read_no_claim_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_rd |=> !rd_valid);
endmodule

// File: rtl/cfgport_unlock.sv
module cfgport_unlock
  import cfgport_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] IDX_PORT = 'h22,
  parameter logic [ADDR_W-1:0] DAT_PORT = 'h23,
  parameter logic [7:0] REV_VALUE = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              alt_func_en,
  output logic              page_addr_en
);
  logic              idx_wr, dat_wr, dat_rd;
  cfg_byte_t         index_q, id_q, mode_q;
  logic              unlocked_q;
  logic [NUM_EN-1:0] en;

  cfgport_decode #(.ADDR_W(ADDR_W), .IDX_PORT(IDX_PORT), .DAT_PORT(DAT_PORT)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en), .rd_addr(rd_addr),
    .idx_wr(idx_wr), .dat_wr(dat_wr), .dat_rd(dat_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      index_q <= '0;
    else if (idx_wr) index_q <= wr_data;
  end

  cfgport_lock u_lock (
    .clk(clk), .rst_n(rst_n), .dat_wr(dat_wr), .index(index_q), .wdata(wr_data),
    .id_q(id_q), .unlocked_q(unlocked_q)
  );

  cfgport_mode u_mode (
    .clk(clk), .rst_n(rst_n), .dat_wr(dat_wr), .index(index_q), .wdata(wr_data),
    .unlocked(unlocked_q), .mode_q(mode_q), .en(en)
  );

  cfgport_rdmux #(.REV_VALUE(REV_VALUE)) u_rd (
    .clk(clk), .rst_n(rst_n), .dat_rd(dat_rd), .index(index_q), .unlocked(unlocked_q),
    .id_q(id_q), .mode_q(mode_q), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign alt_func_en  = en[EN_ALT];
  assign page_addr_en = en[EN_PAGE];

  assert_index_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_wr |=> $stable(index_q));
  assert_index_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> index_q == $past(wr_data));
  assert_foreign_addr_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_wr && !dat_wr) |=> $stable(index_q) && $stable(unlocked_q) && $stable(mode_q));
endmodule

// File: tb/cfgport_unlock_tb.sv
module cfgport_unlock_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] IDXP = 16'h22;
  localparam logic [15:0] DATP = 16'h23;
  localparam logic [7:0]  REV  = 8'h02;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic rd_valid, alt_func_en, page_addr_en;
  logic [7:0] rd_data;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgport_unlock dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .alt_func_en(alt_func_en), .page_addr_en(page_addr_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One bus cycle: drive at a falling edge, release at the next falling edge.
  task automatic cyc(input logic we, input logic [15:0] wa, input logic [7:0] wd,
                     input logic re, input logic [15:0] ra);
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 1'b0, '0);
  endtask

  task automatic rd_check(input string req, input logic ev, input logic [7:0] ed);
    cyc(1'b0, '0, '0, 1'b1, DATP);
    check(req, {23'd0, rd_valid, rd_data}, {23'd0, ev, ev ? ed : 8'h00});
  endtask

  // Bench model of a data-port read response.
  function automatic logic [8:0] model_rd(input logic [7:0] idx, input logic unl,
                                          input logic [7:0] idv, input logic [7:0] mode);
    if (idx == 8'h02) return {1'b1, idv};
    if (unl && idx == 8'h08) return {1'b1, REV};
    if (unl && idx == 8'h40) return {1'b1, mode & 8'h7F};
    return 9'h000;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [8:0] e;
    logic [7:0] mode;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 rd_valid", rd_valid, 0);
    check("R1 page_addr_en", page_addr_en, 1);
    check("R1 alt_func_en", alt_func_en, 0);
    rd_check("R1 R9 index 00 unclaimed", 1'b0, 8'h00);
    wr(IDXP, 8'h02);
    rd_check("R1 R3 id resets 00", 1'b1, 8'h00);
    wr(IDXP, 8'h08);
    rd_check("R1 locked after reset", 1'b0, 8'h00);

    // R5/R9 locked sweep over every index
    for (int i = 0; i < 256; i++) begin
      wr(IDXP, 8'(i));
      e = model_rd(8'(i), 1'b0, 8'h00, 8'h20);
      rd_check("R5 R9 locked sweep", e[8], e[7:0]);
    end
    wr(IDXP, 8'h40);
    wr(DATP, 8'hFF);
    check("R5 locked write alt", alt_func_en, 0);
    check("R5 locked write page", page_addr_en, 1);

    // R4/R3 every id byte: stored, unlocks only for 0Fh
    for (int v = 0; v < 256; v++) begin
      wr(IDXP, 8'h02);
      wr(DATP, 8'(v));
      rd_check("R3 id readback", 1'b1, 8'(v));
      wr(IDXP, 8'h08);
      rd_check("R4 unlock only by key", (v == 15), REV);
    end

    // R4 non-key after unlock relocks, key unlocks again
    wr(IDXP, 8'h02);
    wr(DATP, 8'h0F);
    wr(DATP, 8'h0E);
    wr(IDXP, 8'h40);
    rd_check("R4 relock", 1'b0, 8'h00);
    wr(IDXP, 8'h02);
    wr(DATP, 8'h0F);

    // R9 unlocked sweep over every index
    for (int i = 0; i < 256; i++) begin
      wr(IDXP, 8'(i));
      e = model_rd(8'(i), 1'b1, 8'h0F, 8'h20);
      rd_check("R9 R6 R7 unlocked sweep", e[8], e[7:0]);
    end

    // R6 revision ignores writes
    wr(IDXP, 8'h08);
    wr(DATP, 8'hFF);
    rd_check("R6 revision write ignored", 1'b1, REV);

    // R7/R8 every mode byte
    mode = 8'h20;
    wr(IDXP, 8'h40);
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = DATP; wr_data = 8'(v);
      check("R8 alt before edge", alt_func_en, mode[6]);
      check("R8 page before edge", page_addr_en, mode[5]);
      @(negedge clk);
      wr_en = 1'b0;
      mode = 8'(v) & 8'h7F;
      check("R8 alt after edge", alt_func_en, mode[6]);
      check("R8 page after edge", page_addr_en, mode[5]);
      rd_check("R7 mode readback bit7 zero", 1'b1, mode);
    end

    // R10 foreign addresses and R2 index port not readable
    wr(IDXP, 8'h02);
    wr(16'h0024, 8'h40);
    wr(16'h0021, 8'h40);
    wr(16'h0123, 8'h55);
    wr(16'h0122, 8'h40);
    rd_check("R10 foreign writes inert", 1'b1, 8'h0F);
    cyc(1'b0, '0, '0, 1'b1, IDXP);
    check("R2 index port read unclaimed", {rd_valid, rd_data}, 9'h000);
    cyc(1'b0, '0, '0, 1'b1, 16'h0024);
    check("R9 foreign read unclaimed", {rd_valid, rd_data}, 9'h000);

    // R11 same-cycle read and write
    wr(DATP, 8'h55);
    cyc(1'b1, IDXP, 8'h08, 1'b1, DATP);
    check("R11 old index used", {rd_valid, rd_data}, {1'b1, 8'h55});
    rd_check("R11 new index locked", 1'b0, 8'h00);
    wr(IDXP, 8'h02);
    cyc(1'b1, DATP, 8'h0F, 1'b1, DATP);
    check("R11 old id byte", {rd_valid, rd_data}, {1'b1, 8'h55});
    wr(IDXP, 8'h40);
    cyc(1'b1, DATP, 8'h60, 1'b1, DATP);
    check("R11 old mode", {rd_valid, rd_data}, {1'b1, 8'h7F});
    check("R8 alt set", alt_func_en, 1);

    // R1 reset relocks
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1 reset alt", alt_func_en, 0);
    check("R1 reset page", page_addr_en, 1);
    rd_check("R1 reset index 00", 1'b0, 8'h00);
    wr(IDXP, 8'h40);
    rd_check("R1 reset relocks", 1'b0, 8'h00);
    wr(IDXP, 8'h02);
    rd_check("R1 reset id 00", 1'b1, 8'h00);

    summary();
    $finish;
  end
endmodule